// File: doc/BRIEF.md
# Module-Carrier Local-Space Router

This block sits between a host-side access port and four plug-in module slots on a carrier card. Each host access names one of four windows: a byte-wide configuration space, a combined register window that reaches each module's identification, interrupt and I/O spaces, a 16-bit memory window and an 8-bit memory window. The block splits the address into a slot number, a sub-space and an offset, and raises a one-cycle strobe towards the addressed slot together with a shared space code, offset, write data and size.

Two of the routed windows can be switched to big-endian lane order by a flag held in the configuration space. The flag makes byte accesses use the partner byte address and swaps the two bytes of halfword write and read data. A third flag sits beside them and is passed out to the neighbouring carrier control-register block. Slots report whether a module is fitted. An access to an empty slot, or an access of the wrong size, reaches no module.

Top module: `lspace_router`

## Requirements
- R1: Register window (h_win=1): slot = h_addr[9:8], sub-space = h_addr[7:6]. Sub-space 2 gives m_space=1 (ID), 3 gives m_space=2 (INT), 0 or 1 gives m_space=0 (I/O). The strobe m_sel is one-hot on the slot bit.
- R2: In the register window the offset on m_addr is h_addr[6:0] for I/O and h_addr[5:0] for ID and INT. All higher m_addr bits are zero.
- R3: 16-bit memory window (h_win=2): slot = h_addr[24:23], m_space=3, m_addr = h_addr[22:0]. Byte and halfword sizes are accepted.
- R4: 8-bit memory window (h_win=3): slot = h_addr[23:22], m_space=4, m_addr = h_addr[21:0]. No endian adjustment applies here.
- R5: A halfword access (h_size=1) in the 8-bit window raises no strobe, and a read there returns zero.
- R6: When the window's swap flag is set, a byte access (h_size=0) is decoded from h_addr with bit 0 inverted.
- R7: When the window's swap flag is set, a halfword access presents m_wdata = {h_wdata[7:0], h_wdata[15:8]}, and the returned read data has its two bytes exchanged. Byte reads are returned unchanged.
- R8: A configuration write (h_win=0, h_we=1) to byte index 0x2F loads h_wdata[0] into the register-window swap flag. Index 0x33 loads the 16-bit-window swap flag. Index 0x2B loads the flag driven on ctl_swap. Reading one of these bytes returns its constant OR the flag in bit 0. Configuration accesses raise no strobe.
- R9: A configuration read of index i below 88 returns ((i*29 mod 256) XOR 0xA6) AND 0xFE in h_rdata[7:0]. Indexes from 88 upwards read zero. Writes to any other index change nothing.
- R10: A routed access to a slot whose m_present bit is 0 raises no strobe. A read of such a slot returns zero.
- R11: The strobe appears in the same cycle as h_valid. h_rvalid is high exactly in the cycle after each h_valid, with h_rdata. A write returns zero data.
- R12: Reset clears all three swap flags and h_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_valid | input | 1 | Host access request, one cycle per access |
| h_we | input | 1 | 1 = write, 0 = read |
| h_win | input | 2 | Window: 0 config, 1 register, 2 mem16, 3 mem8 |
| h_size | input | 1 | 0 = byte, 1 = halfword |
| h_addr | input | 25 | Byte address within the window |
| h_wdata | input | 16 | Write data |
| h_rvalid | output | 1 | Response strobe, one cycle after h_valid |
| h_rdata | output | 16 | Read data |
| ctl_swap | output | 1 | Swap flag for the carrier control-register window |
| m_present | input | 4 | Module fitted, one bit per slot |
| m_sel | output | 4 | Per-slot access strobe |
| m_space | output | 3 | 0 I/O, 1 ID, 2 INT, 3 mem16, 4 mem8 |
| m_we | output | 1 | Write enable to modules |
| m_size | output | 1 | Access size to modules |
| m_addr | output | 23 | Offset within the selected space |
| m_wdata | output | 16 | Write data after lane adjustment |
| m_rdata | input | 64 | Read data, 16 bits per slot, slot 0 in the low bits |

## Verification
The hardest case to reach is a byte access in a swapped window whose inverted bit 0 changes the decoded offset. The same window must also return unswapped data for byte reads and swapped data for halfword reads. The stimulus first sets the flags through the configuration window, reading each flag byte back. It then reuses addresses from the unswapped vector table, so each result can be compared with its unswapped counterpart. Empty slots are reached by clearing one m_present bit between accesses.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

   typedef enum logic [1:0] {
      WIN_CFG = 2'd0,
      WIN_REG = 2'd1,
      WIN_M16 = 2'd2,
      WIN_M8  = 2'd3
   } win_e;

   typedef enum logic [2:0] {
      SP_IO  = 3'd0,
      SP_ID  = 3'd1,
      SP_INT = 3'd2,
      SP_M16 = 3'd3,
      SP_M8  = 3'd4
   } space_e;

   // configuration byte indexes holding the swap flags
   localparam logic [7:0] CFG_SWAP_CTL = 8'h2B;
   localparam logic [7:0] CFG_SWAP_REG = 8'h2F;
   localparam logic [7:0] CFG_SWAP_M16 = 8'h33;

   function automatic logic [15:0] bswap16(input logic [15:0] d);
      return {d[7:0], d[15:8]};
   endfunction

   // fixed configuration content, computed instead of tabulated
   function automatic logic [7:0] cfg_const(input logic [7:0] idx);
      logic [7:0] p;
      p = idx * 8'd29;
      return (p ^ 8'hA6) & 8'hFE;
   endfunction

endpackage

// File: rtl/lsr_decode.sv
module lsr_decode
   import lsr_pkg::*;
#(
   parameter int SLOTS     = 4,
   parameter int SLOT_W    = 2,
   parameter int REG_OFF_W = 8,
   parameter int M16_OFF_W = 23,
   localparam int AW       = M16_OFF_W + SLOT_W
) (
   input  logic                 h_valid,
   input  logic [1:0]           h_win,
   input  logic                 h_size,
   input  logic [AW-1:0]        h_addr,
   input  logic [15:0]          h_wdata,
   input  logic                 swap_reg,
   input  logic                 swap_m16,
   input  logic [SLOTS-1:0]     m_present,
   output logic [SLOTS-1:0]     m_sel,
   output logic [2:0]           m_space,
   output logic [M16_OFF_W-1:0] m_addr,
   output logic [15:0]          m_wdata,
   output logic                 hit,
   output logic [SLOT_W-1:0]    slot,
   output logic                 swap_hw
);
   localparam int M8_OFF_W = M16_OFF_W - 1;
   localparam int IO_OFF_W = REG_OFF_W - 1;
   localparam int ID_OFF_W = REG_OFF_W - 2;

   win_e                 win;
   logic                 swap_win;
   logic                 legal;
   logic [AW-1:0]        ea;
   logic [1:0]           sub;
   space_e               space;
   logic [M16_OFF_W-1:0] off;

   always_comb begin
      win      = win_e'(h_win);
      swap_win = (win == WIN_REG) ? swap_reg :
                 (win == WIN_M16) ? swap_m16 : 1'b0;
      ea       = h_addr ^ {{(AW-1){1'b0}}, swap_win & ~h_size};
      slot     = '0;
      space    = SP_IO;
      off      = '0;
      legal    = 1'b0;
      sub      = ea[REG_OFF_W-1 -: 2];
      case (win)
         WIN_REG: begin
            slot  = ea[REG_OFF_W +: SLOT_W];
            legal = 1'b1;
            case (sub)
               2'd2: begin
                  space = SP_ID;
                  off[ID_OFF_W-1:0] = ea[ID_OFF_W-1:0];
               end
               2'd3: begin
                  space = SP_INT;
                  off[ID_OFF_W-1:0] = ea[ID_OFF_W-1:0];
               end
               default: begin
                  space = SP_IO;
                  off[IO_OFF_W-1:0] = ea[IO_OFF_W-1:0];
               end
            endcase
         end
         WIN_M16: begin
            slot  = ea[M16_OFF_W +: SLOT_W];
            space = SP_M16;
            off   = ea[M16_OFF_W-1:0];
            legal = 1'b1;
         end
         WIN_M8: begin
            slot  = ea[M8_OFF_W +: SLOT_W];
            space = SP_M8;
            off[M8_OFF_W-1:0] = ea[M8_OFF_W-1:0];
            legal = ~h_size;
         end
         default: legal = 1'b0;
      endcase
      hit     = h_valid & legal & m_present[slot];
      swap_hw = swap_win & h_size;
      m_wdata = swap_hw ? bswap16(h_wdata) : h_wdata;
      m_space = space;
      m_addr  = off;
   end

   for (genvar g = 0; g < SLOTS; g++) begin : g_strobe
      assign m_sel[g] = hit && (slot == SLOT_W'(g));
   end

endmodule

// File: rtl/lsr_cfg.sv
module lsr_cfg
   import lsr_pkg::*;
#(
   parameter int CFG_BYTES = 88,
   parameter int CFG_IDX_W = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc,
   input  logic                 we,
   input  logic [CFG_IDX_W-1:0] idx,
   input  logic                 wbit,
   output logic                 swap_ctl,
   output logic                 swap_reg,
   output logic                 swap_m16,
   output logic [7:0]           rd_byte
);
   localparam int NFLAG = 3;
   localparam logic [7:0] FLAG_IDX [NFLAG] = '{CFG_SWAP_CTL, CFG_SWAP_REG, CFG_SWAP_M16};

   logic [NFLAG-1:0] flag;
   logic [7:0]       idx8;

   assign idx8 = 8'(idx);

   for (genvar g = 0; g < NFLAG; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag[g] <= 1'b0;
         else if (acc && we && idx8 == FLAG_IDX[g])
            flag[g] <= wbit;
      end
   end

   always_comb begin
      rd_byte = (int'(idx) < CFG_BYTES) ? cfg_const(idx8) : 8'h00;
      for (int k = 0; k < NFLAG; k++) begin
         if (idx8 == FLAG_IDX[k])
            rd_byte[0] = rd_byte[0] | flag[k];
      end
   end

   assign swap_ctl = flag[0];
   assign swap_reg = flag[1];
   assign swap_m16 = flag[2];

endmodule

// File: rtl/lsr_resp.sv
module lsr_resp
   import lsr_pkg::*;
#(
   parameter int SLOTS  = 4,
   parameter int SLOT_W = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                h_valid,
   input  logic                h_we,
   input  logic                is_cfg,
   input  logic [7:0]          cfg_byte,
   input  logic                hit,
   input  logic [SLOT_W-1:0]   slot,
   input  logic                swap_hw,
   input  logic [SLOTS*16-1:0] m_rdata,
   output logic                h_rvalid,
   output logic [15:0]         h_rdata
);
   logic [15:0] lane;
   logic [15:0] nxt;

   always_comb begin
      lane = m_rdata[{slot, 4'b0000} +: 16];
      nxt  = '0;
      if (!h_we) begin
         if (is_cfg)
            nxt = {8'h00, cfg_byte};
         else if (hit)
            nxt = swap_hw ? bswap16(lane) : lane;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_rvalid <= 1'b0;
         h_rdata  <= '0;
      end else begin
         h_rvalid <= h_valid;
         h_rdata  <= h_valid ? nxt : '0;
      end
   end

endmodule

// File: rtl/lspace_router.sv
module lspace_router
   import lsr_pkg::*;
#(
   parameter int SLOTS     = 4,
   parameter int REG_OFF_W = 8,
   parameter int M16_OFF_W = 23,
   parameter int CFG_BYTES = 88,
   parameter int CFG_SPAN  = 128,
   localparam int SLOT_W    = $clog2(SLOTS),
   localparam int AW        = M16_OFF_W + SLOT_W,
   localparam int CFG_IDX_W = $clog2(CFG_SPAN)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 h_valid,
   input  logic                 h_we,
   input  logic [1:0]           h_win,
   input  logic                 h_size,
   input  logic [AW-1:0]        h_addr,
   input  logic [15:0]          h_wdata,
   output logic                 h_rvalid,
   output logic [15:0]          h_rdata,
   output logic                 ctl_swap,
   input  logic [SLOTS-1:0]     m_present,
   output logic [SLOTS-1:0]     m_sel,
   output logic [2:0]           m_space,
   output logic                 m_we,
   output logic                 m_size,
   output logic [M16_OFF_W-1:0] m_addr,
   output logic [15:0]          m_wdata,
   input  logic [SLOTS*16-1:0]  m_rdata
);
   if (SLOTS < 2 || (1 << SLOT_W) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two, at least 2");
   end
   if (REG_OFF_W < 3 || REG_OFF_W + SLOT_W > M16_OFF_W) begin : g_bad_reg
      $error("REG_OFF_W out of range");
   end
   if (CFG_BYTES > CFG_SPAN || CFG_SPAN <= 8'h33 || CFG_SPAN > 256) begin : g_bad_cfg
      $error("configuration span does not hold the flag bytes");
   end

   logic              swap_reg, swap_m16;
   logic              hit, swap_hw, is_cfg;
   logic [SLOT_W-1:0] slot;
   logic [7:0]        cfg_byte;

   assign is_cfg = h_valid && (h_win == WIN_CFG);
   assign m_we   = h_we;
   assign m_size = h_size;

   lsr_decode #(
      .SLOTS(SLOTS), .SLOT_W(SLOT_W),
      .REG_OFF_W(REG_OFF_W), .M16_OFF_W(M16_OFF_W)
   ) u_dec (
      .h_valid(h_valid), .h_win(h_win), .h_size(h_size),
      .h_addr(h_addr), .h_wdata(h_wdata),
      .swap_reg(swap_reg), .swap_m16(swap_m16), .m_present(m_present),
      .m_sel(m_sel), .m_space(m_space), .m_addr(m_addr), .m_wdata(m_wdata),
      .hit(hit), .slot(slot), .swap_hw(swap_hw)
   );

   lsr_cfg #(.CFG_BYTES(CFG_BYTES), .CFG_IDX_W(CFG_IDX_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .acc(is_cfg), .we(h_we),
      .idx(h_addr[CFG_IDX_W-1:0]), .wbit(h_wdata[0]),
      .swap_ctl(ctl_swap), .swap_reg(swap_reg), .swap_m16(swap_m16),
      .rd_byte(cfg_byte)
   );

   lsr_resp #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_resp (
      .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_we(h_we),
      .is_cfg(is_cfg), .cfg_byte(cfg_byte), .hit(hit), .slot(slot),
      .swap_hw(swap_hw), .m_rdata(m_rdata),
      .h_rvalid(h_rvalid), .h_rdata(h_rdata)
   );

endmodule

// File: rtl/lspace_router_chk.sv
module lspace_router_chk #(
   parameter int SLOTS     = 4,
   parameter int REG_OFF_W = 8,
   parameter int M16_OFF_W = 23
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 h_valid,
   input logic [1:0]           h_win,
   input logic [SLOTS-1:0]     m_present,
   input logic [SLOTS-1:0]     m_sel,
   input logic [2:0]           m_space,
   input logic                 m_size,
   input logic [M16_OFF_W-1:0] m_addr,
   input logic                 h_rvalid
);
   AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(m_sel)); // R1

   AST_IDINT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      (m_sel != '0 && (m_space == 3'd1 || m_space == 3'd2)) |->
         ((m_addr >> (REG_OFF_W - 2)) == '0)); // R2

   AST_M8_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (m_sel != '0 && m_space == 3'd4) |-> !m_size); // R5

   AST_CFG_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (h_valid && h_win == 2'd0) |-> (m_sel == '0)); // R8

   AST_ABSENT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (m_sel & ~m_present) == '0); // R10

   AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !h_valid |-> (m_sel == '0)); // R11

   AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      h_valid |=> h_rvalid); // R11

   AST_RVALID_ONLY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      !h_valid |=> !h_rvalid); // R11

endmodule

bind lspace_router lspace_router_chk #(
   .SLOTS(SLOTS), .REG_OFF_W(REG_OFF_W), .M16_OFF_W(M16_OFF_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_win(h_win),
   .m_present(m_present), .m_sel(m_sel), .m_space(m_space),
   .m_size(m_size), .m_addr(m_addr), .h_rvalid(h_rvalid)
);

// File: tb/lspace_router_tb.sv
module lspace_router_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_valid = 1'b0;
   logic        h_we = 1'b0;
   logic [1:0]  h_win = '0;
   logic        h_size = 1'b0;
   logic [24:0] h_addr = '0;
   logic [15:0] h_wdata = '0;
   logic        h_rvalid;
   logic [15:0] h_rdata;
   logic        ctl_swap;
   logic [3:0]  m_present = 4'b1111;
   logic [3:0]  m_sel;
   logic [2:0]  m_space;
   logic        m_we;
   logic        m_size;
   logic [22:0] m_addr;
   logic [15:0] m_wdata;
   logic [63:0] m_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [3:0]  c_sel;
   logic [2:0]  c_space;
   logic [22:0] c_addr;
   logic [15:0] c_wdata;
   logic        c_rvalid;
   logic [15:0] c_rdata;

   always #5 clk = ~clk;

   lspace_router u_dut (
      .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_we(h_we),
      .h_win(h_win), .h_size(h_size), .h_addr(h_addr), .h_wdata(h_wdata),
      .h_rvalid(h_rvalid), .h_rdata(h_rdata), .ctl_swap(ctl_swap),
      .m_present(m_present), .m_sel(m_sel), .m_space(m_space),
      .m_we(m_we), .m_size(m_size), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_rdata(m_rdata)
   );

   function automatic logic [15:0] rd_pat(input int s);
      return 16'hA0B0 | 16'(s << 8) | 16'(s);
   endfunction

   function automatic logic [7:0] tbl(input int i);
      logic [7:0] p;
      if (i >= 88) return 8'h00;
      p = 8'(i * 29);
      return (p ^ 8'hA6) & 8'hFE;
   endfunction

   assign m_rdata = {rd_pat(3), rd_pat(2), rd_pat(1), rd_pat(0)};

   typedef struct packed {
      logic [1:0]  win;
      logic        we;
      logic        sz;
      logic [24:0] addr;
      logic [15:0] wd;
      logic [3:0]  sel;
      logic [2:0]  sp;
      logic [22:0] oa;
      logic [15:0] ow;
      logic [15:0] rd;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VEC [NVEC] = '{
      '{2'd1, 1'b1, 1'b0, 25'h00000C5, 16'h0012, 4'b0001, 3'd2, 23'h000005, 16'h0012, 16'h0000},
      '{2'd1, 1'b0, 1'b1, 25'h00001A4, 16'h0000, 4'b0010, 3'd1, 23'h000024, 16'h0000, 16'hA1B1},
      '{2'd1, 1'b1, 1'b0, 25'h000027F, 16'h0034, 4'b0100, 3'd0, 23'h00007F, 16'h0034, 16'h0000},
      '{2'd1, 1'b0, 1'b0, 25'h000033A, 16'h0000, 4'b1000, 3'd0, 23'h00003A, 16'h0000, 16'hA3B3},
      '{2'd2, 1'b1, 1'b1, 25'h1812345, 16'hBEEF, 4'b1000, 3'd3, 23'h012345, 16'hBEEF, 16'h0000},
      '{2'd2, 1'b0, 1'b1, 25'h0900010, 16'h0000, 4'b0010, 3'd3, 23'h100010, 16'h0000, 16'hA1B1},
      '{2'd3, 1'b1, 1'b0, 25'h0ABCDEF, 16'h0056, 4'b0100, 3'd4, 23'h2BCDEF, 16'h0056, 16'h0000},
      '{2'd3, 1'b0, 1'b0, 25'h0C00001, 16'h0000, 4'b1000, 3'd4, 23'h000001, 16'h0000, 16'hA3B3},
      '{2'd3, 1'b0, 1'b1, 25'h0400000, 16'h0000, 4'b0000, 3'd0, 23'h000000, 16'h0000, 16'h0000},
      '{2'd0, 1'b0, 1'b0, 25'h000002B, 16'h0000, 4'b0000, 3'd0, 23'h000000, 16'h0000, 16'h0078}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic acc(input logic [1:0] win, input logic we, input logic sz,
                      input logic [24:0] addr, input logic [15:0] wd);
      @(negedge clk);
      h_valid = 1'b1; h_win = win; h_we = we; h_size = sz;
      h_addr = addr; h_wdata = wd;
      #1;
      c_sel = m_sel; c_space = m_space; c_addr = m_addr; c_wdata = m_wdata;
      @(negedge clk);
      h_valid = 1'b0; h_we = 1'b0;
      #1;
      c_rvalid = h_rvalid; c_rdata = h_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R12: reset state
      repeat (3) @(negedge clk);
      check("R12 rvalid in reset", 32'(h_rvalid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 ctl_swap after reset", 32'(ctl_swap), 0);
      check("R11 no strobe when idle", 32'(m_sel), 0);
      acc(2'd0, 1'b0, 1'b0, 25'h2F, 16'h0);
      check("R12 reg flag clear", 32'(c_rdata), 32'(tbl(8'h2F)));
      acc(2'd0, 1'b0, 1'b0, 25'h33, 16'h0);
      check("R12 m16 flag clear", 32'(c_rdata), 32'(tbl(8'h33)));

      // vector table, all flags clear, all slots fitted
      for (int i = 0; i < NVEC; i++) begin
         string tag;
         tag = (VEC[i].win == 2'd1) ? "R1 R2" :
               (VEC[i].win == 2'd2) ? "R3" :
               (i == 8) ? "R5" :
               (VEC[i].win == 2'd3) ? "R4" : "R9";
         acc(VEC[i].win, VEC[i].we, VEC[i].sz, VEC[i].addr, VEC[i].wd);
         check({tag, " strobe"}, 32'(c_sel), 32'(VEC[i].sel));
         if (VEC[i].sel != 0) begin
            check({tag, " space"}, 32'(c_space), 32'(VEC[i].sp));
            check({tag, " offset"}, 32'(c_addr), 32'(VEC[i].oa));
            if (VEC[i].we) check({tag, " wdata"}, 32'(c_wdata), 32'(VEC[i].ow));
         end
         check("R11 rvalid", 32'(c_rvalid), 1);
         check({tag, " rdata"}, 32'(c_rdata), 32'(VEC[i].rd));
      end

      // R9: other config indexes
      acc(2'd0, 1'b0, 1'b0, 25'h00, 16'h0);
      check("R9 cfg byte 0", 32'(c_rdata), 32'(tbl(0)));
      acc(2'd0, 1'b0, 1'b0, 25'h57, 16'h0);
      check("R9 cfg last byte", 32'(c_rdata), 32'(tbl(87)));
      acc(2'd0, 1'b0, 1'b0, 25'h7F, 16'h0);
      check("R9 cfg beyond table", 32'(c_rdata), 0);

      // R8 + R6 + R7: register window swap
      acc(2'd0, 1'b1, 1'b0, 25'h2F, 16'h0001);
      check("R8 cfg write no strobe", 32'(c_sel), 0);
      acc(2'd0, 1'b0, 1'b0, 25'h2F, 16'h0);
      check("R8 reg flag readback", 32'(c_rdata), 32'(tbl(8'h2F) | 8'h01));
      acc(2'd1, 1'b1, 1'b0, 25'h0C4, 16'h0012);
      check("R6 byte addr flipped", 32'(c_addr), 32'h05);
      check("R6 byte wdata unswapped", 32'(c_wdata), 32'h0012);
      acc(2'd1, 1'b1, 1'b1, 25'h0C4, 16'h1234);
      check("R7 half offset", 32'(c_addr), 32'h04);
      check("R7 half wdata swapped", 32'(c_wdata), 32'h3412);
      acc(2'd1, 1'b0, 1'b1, 25'h1A4, 16'h0);
      check("R7 half rdata swapped", 32'(c_rdata), 32'hB1A1);
      acc(2'd1, 1'b0, 1'b0, 25'h1A4, 16'h0);
      check("R6 byte read offset", 32'(c_addr), 32'h25);
      check("R7 byte rdata unswapped", 32'(c_rdata), 32'hA1B1);

      // R8: 16-bit window flag, 8-bit window untouched (R4)
      acc(2'd0, 1'b1, 1'b0, 25'h33, 16'h0001);
      acc(2'd0, 1'b0, 1'b0, 25'h33, 16'h0);
      check("R8 m16 flag readback", 32'(c_rdata), 32'(tbl(8'h33) | 8'h01));
      acc(2'd2, 1'b1, 1'b0, 25'h0900010, 16'h0077);
      check("R6 m16 byte addr flipped", 32'(c_addr), 32'h100011);
      acc(2'd2, 1'b0, 1'b1, 25'h0900010, 16'h0);
      check("R7 m16 half rdata swapped", 32'(c_rdata), 32'hB1A1);
      acc(2'd3, 1'b0, 1'b0, 25'h0C00001, 16'h0);
      check("R4 m8 no addr flip", 32'(c_addr), 32'h1);
      check("R4 m8 rdata unswapped", 32'(c_rdata), 32'hA3B3);

      // R8: control flag output
      acc(2'd0, 1'b1, 1'b0, 25'h2B, 16'h0001);
      check("R8 ctl_swap set", 32'(ctl_swap), 1);
      acc(2'd0, 1'b0, 1'b0, 25'h2B, 16'h0);
      check("R8 ctl flag readback", 32'(c_rdata), 32'(tbl(8'h2B) | 8'h01));

      // R9: write to other index has no effect
      acc(2'd0, 1'b1, 1'b0, 25'h10, 16'h00FF);
      acc(2'd0, 1'b0, 1'b0, 25'h10, 16'h0);
      check("R9 plain cfg write ignored", 32'(c_rdata), 32'(tbl(16)));
      check("R9 flags kept", 32'(ctl_swap), 1);

      // R10: empty slot 2
      m_present = 4'b1011;
      acc(2'd1, 1'b0, 1'b0, 25'h23A, 16'h0);
      check("R10 absent read strobe", 32'(c_sel), 0);
      check("R10 absent read data", 32'(c_rdata), 0);
      acc(2'd3, 1'b1, 1'b0, 25'h0ABCDEF, 16'h0099);
      check("R10 absent write strobe", 32'(c_sel), 0);
      acc(2'd1, 1'b0, 1'b0, 25'h13A, 16'h0);
      check("R10 fitted slot still served", 32'(c_sel), 32'b0010);
      m_present = 4'b1111;

      // R11: response lasts one cycle
      @(negedge clk);
      #1;
      check("R11 rvalid drops when idle", 32'(h_rvalid), 0);

      // R12: reset clears flags
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R12 ctl_swap cleared", 32'(ctl_swap), 0);
      acc(2'd1, 1'b0, 1'b1, 25'h1A4, 16'h0);
      check("R12 reg swap cleared", 32'(c_rdata), 32'hA1B1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule